// File: doc/BRIEF.md
# Marker-Terminated UART Transmitter

This block serialises one byte at a time onto an asynchronous line. Each frame has ten bit periods: a low start bit, eight data bits sent least significant first, and a high stop bit. A byte is handed over through a valid/ready input. The bit period comes from a free-running prescaler that counts pulses of a system sample tick and emits one bit tick for every sixteen of them.

The block keeps no bit counter. On acceptance, the byte goes into a nine-position shift register whose top position holds a single 1 marker. Zeros refill the register from the top as bits leave from the bottom. The block knows a frame has ended when the register holds only the marker, and then when the register is empty. The accepted byte does not start on the line at the moment of the handshake. The start bit waits for the next bit tick of the prescaler, and a write never restarts the prescaler.

When the stop bit begins, a sticky done flag is raised. It stays up until a clear pulse arrives. Back-pressure rules: `in_ready` is high only while no frame is pending or in flight. A byte is taken on a rising clock edge where `in_valid` and `in_ready` are both high. While `in_ready` is low, `in_valid` and `in_data` are ignored. A held byte is not queued for later.

Top module: `uart_mtx_top`

## Requirements
- R1: After reset, and at once while `rst_n` is low (asynchronous), `txd` is 1, `done_flag` is 0 and `in_ready` is 1. A reset during a frame abandons that frame.
- R2: A byte is accepted on an edge with `in_valid` and `in_ready` both high, and `in_ready` is 0 from the next cycle. While `in_ready` is 0, `in_valid` and `in_data` have no effect: the current frame still carries the accepted byte, and no further frame follows.
- R3: A bit tick occurs on each edge where `sample_tick` is 1 and it is the 16th, 32nd, 48th, ... such pulse counted since reset. Writes never reset this count. `txd` changes only on bit-tick edges.
- R4: The start bit (`txd` = 0) begins on the first bit-tick edge strictly after the accepting edge. Until then `txd` stays 1.
- R5: On bit ticks 2 through 9 after acceptance, `txd` carries data bits 0 through 7 in that order, bit 0 being the least significant bit of `in_data`.
- R6: On bit tick 10 after acceptance, `txd` goes to 1 (stop bit) and `done_flag` rises on that same edge. Before that edge, `done_flag` remains 0 during the frame.
- R7: On bit tick 11 after acceptance, the stop bit ends. `in_ready` returns to 1 and `txd` stays 1.
- R8: `done_flag` stays 1 until `done_clr` is 1 on a clock edge, and it is 0 from that edge on. If a new flag event coincides with a clear, the event wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_tick | input | 1 | Oversampling pulse, one clock wide |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Transmitter idle, byte can be taken |
| in_data | input | 8 | Byte to send |
| done_clr | input | 1 | Clears the done flag |
| txd | output | 1 | Serial line, idles high |
| done_flag | output | 1 | Sticky frame-complete flag |

## Verification
A shift register that loses its marker, or that fills with ones instead of zeros, shows up at the line. It either stretches the frame past tick 11 or ends it early, so `in_ready` or the stop level is wrong within one bit period of the tenth tick. A prescaler that restarts on a write or miscounts moves every line edge off the bench's own tick count, and this is visible at the start bit of the first frame. A phase register that accepts a byte while busy corrupts the data bits of the running frame, or adds a frame the bench sees as a falling `txd` where the line should stay idle.

// File: rtl/uart_mtx_pkg.sv
package uart_mtx_pkg;
  // Transmit sequencing phases
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,  // waiting for a byte
    PH_ARMED = 2'd1,  // byte loaded, waiting for next bit tick
    PH_START = 2'd2,  // start bit on the line
    PH_SHIFT = 2'd3   // data / stop bits driven from the shift register
  } tx_phase_t;
endpackage

// File: rtl/uart_mtx_prescale.sv
module uart_mtx_prescale #(
  parameter int RATIO = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_tick,
  output logic bit_tick
);
  localparam int CW = (RATIO > 2) ? $clog2(RATIO) : 1;
  localparam logic [CW-1:0] TOP = CW'(RATIO - 1);

  logic [CW-1:0] cnt_q;

  // Free running: only reset clears it, never a write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (sample_tick) begin
      cnt_q <= (cnt_q == TOP) ? '0 : cnt_q + 1'b1;
    end
  end

  assign bit_tick = sample_tick && (cnt_q == TOP);
endmodule

// File: rtl/uart_mtx_shreg.sv
module uart_mtx_shreg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic [DATA_W-1:0] load_data,
  output logic              cur_bit,
  output logic              next_bit,
  output logic              to_marker,
  output logic              to_empty
);
  localparam int SR_W = DATA_W + 1;

  logic [SR_W-1:0] sr_q;

  // Marker sits above the data; zeros enter from the top on every shift
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else if (load) begin
      sr_q <= {1'b1, load_data};
    end else if (shift) begin
      sr_q <= {1'b0, sr_q[SR_W-1:1]};
    end
  end

  assign cur_bit   = sr_q[0];
  assign next_bit  = sr_q[1];
  // After the next shift only the marker remains: last (stop) bit state
  assign to_marker = (sr_q[SR_W-1:1] == DATA_W'(1));
  // After the next shift nothing remains: frame finished
  assign to_empty  = (sr_q == SR_W'(1));
endmodule

// File: rtl/uart_mtx_ctrl.sv
module uart_mtx_ctrl
  import uart_mtx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic in_valid,
  input  logic done_clr,
  input  logic sr_cur_bit,
  input  logic sr_next_bit,
  input  logic sr_to_marker,
  input  logic sr_to_empty,
  output logic in_ready,
  output logic load,
  output logic shift,
  output logic txd,
  output logic done_flag
);
  tx_phase_t phase_q;

  assign in_ready = (phase_q == PH_IDLE);
  assign load     = in_valid && in_ready;
  assign shift    = bit_tick && (phase_q == PH_SHIFT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      txd     <= 1'b1;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (load) phase_q <= PH_ARMED;
        end
        PH_ARMED: begin
          if (bit_tick) begin
            phase_q <= PH_START;
            txd     <= 1'b0;
          end
        end
        PH_START: begin
          if (bit_tick) begin
            phase_q <= PH_SHIFT;
            txd     <= sr_cur_bit;
          end
        end
        PH_SHIFT: begin
          if (bit_tick) begin
            if (sr_to_empty) begin
              phase_q <= PH_IDLE;
              txd     <= 1'b1;
            end else begin
              // the marker itself provides the stop level
              txd <= sr_next_bit;
            end
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  // Sticky completion flag: a new event outranks a clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_flag <= 1'b0;
    end else if (shift && sr_to_marker) begin
      done_flag <= 1'b1;
    end else if (done_clr) begin
      done_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_mtx_top.sv
module uart_mtx_top #(
  parameter int DATA_W = 8,
  parameter int RATIO  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_tick,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              done_clr,
  output logic              txd,
  output logic              done_flag
);
  logic w_bit_tick;
  logic w_load;
  logic w_shift;
  logic w_cur_bit;
  logic w_next_bit;
  logic w_to_marker;
  logic w_to_empty;

  uart_mtx_prescale #(.RATIO(RATIO)) i_prescale (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_tick (sample_tick),
    .bit_tick    (w_bit_tick)
  );

  uart_mtx_shreg #(.DATA_W(DATA_W)) i_shreg (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (w_load),
    .shift     (w_shift),
    .load_data (in_data),
    .cur_bit   (w_cur_bit),
    .next_bit  (w_next_bit),
    .to_marker (w_to_marker),
    .to_empty  (w_to_empty)
  );

  uart_mtx_ctrl i_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_tick     (w_bit_tick),
    .in_valid     (in_valid),
    .done_clr     (done_clr),
    .sr_cur_bit   (w_cur_bit),
    .sr_next_bit  (w_next_bit),
    .sr_to_marker (w_to_marker),
    .sr_to_empty  (w_to_empty),
    .in_ready     (in_ready),
    .load         (w_load),
    .shift        (w_shift),
    .txd          (txd),
    .done_flag    (done_flag)
  );
endmodule

// File: rtl/uart_mtx_chk.sv
module uart_mtx_chk (
  input logic clk,
  input logic rst_n,
  input logic sample_tick,
  input logic bit_tick,
  input logic in_valid,
  input logic in_ready,
  input logic done_clr,
  input logic txd,
  input logic done_flag
);
  p_idle_line_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> txd);

  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  p_tick_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> sample_tick);

  p_line_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(txd) |-> $past(bit_tick));

  p_done_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> ($past(bit_tick) && txd));

  p_ready_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> $past(bit_tick));

  p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_flag && !done_clr) |=> done_flag);

  p_done_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_clr && !bit_tick) |=> !done_flag);
endmodule

bind uart_mtx_top uart_mtx_chk i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sample_tick (sample_tick),
  .bit_tick    (w_bit_tick),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .done_clr    (done_clr),
  .txd         (txd),
  .done_flag   (done_flag)
);

// File: tb/test_uart_mtx_top.sv
`timescale 1ns/1ps
module test_uart_mtx_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       sample_tick;
  logic       in_valid;
  logic       in_ready;
  logic [7:0] in_data;
  logic       done_clr;
  logic       txd;
  logic       done_flag;

  int          total = 0;
  int          bad = 0;
  int          samp_div = 1;
  int unsigned bticks = 0;
  int          scnt = 0;
  bit          finished = 1'b0;

  always #2.5 clk = ~clk;

  uart_mtx_top i_uart_mtx_top (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_tick (sample_tick),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_data     (in_data),
    .done_clr    (done_clr),
    .txd         (txd),
    .done_flag   (done_flag)
  );

  // Sample tick generator: one pulse every samp_div cycles
  initial begin
    int ph = 0;
    sample_tick = 1'b0;
    forever begin
      @(negedge clk);
      ph = (ph + 1 >= samp_div) ? 0 : ph + 1;
      sample_tick = (ph == 0);
    end
  end

  // Independent bit tick model: every 16th sample tick since reset
  initial begin
    forever begin
      @(posedge clk);
      if (!rst_n) begin
        scnt = 0;
      end else if (sample_tick) begin
        if (scnt == 15) begin
          scnt = 0;
          bticks++;
        end else begin
          scnt++;
        end
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // Wait for bit tick number target; verify txd holds lvl meanwhile (R3)
  task automatic wait_tick(input int unsigned target, input logic lvl, output bit held);
    held = 1'b1;
    while (bticks < target) begin
      if (txd !== lvl) held = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic send_frame(input logic [7:0] d, input bit noisy);
    int unsigned b0;
    bit held;
    logic prev;
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    @(negedge clk);
    in_valid = 1'b0;
    b0 = bticks;
    chk("R2", "ready after accept", int'(in_ready), 0);
    chk("R4", "line before start", int'(txd), 1);
    prev = 1'b1;
    for (int k = 1; k <= 11; k++) begin
      wait_tick(b0 + k, prev, held);
      chk("R3", $sformatf("line steady before tick %0d", k), int'(held), 1);
      if (k == 1) begin
        chk("R4", "start bit", int'(txd), 0);
        prev = 1'b0;
      end else if (k <= 9) begin
        chk("R5", $sformatf("data bit %0d of 0x%02h", k - 2, d), int'(txd), int'(d[k-2]));
        prev = d[k-2];
        if (k == 9) chk("R6", "done low before stop", int'(done_flag), 0);
      end else if (k == 10) begin
        chk("R6", "stop level", int'(txd), 1);
        chk("R6", "done at tick 10", int'(done_flag), 1);
        chk("R2", "busy during stop", int'(in_ready), 0);
        prev = 1'b1;
      end else begin
        chk("R7", "ready at tick 11", int'(in_ready), 1);
        chk("R7", "line high at tick 11", int'(txd), 1);
      end
      // ignored writes while busy
      if (noisy && k == 3) begin
        in_valid = 1'b1;
        in_data  = ~d;
      end
      if (noisy && k == 5) in_valid = 1'b0;
    end
    // done stays set until cleared
    repeat (5) @(negedge clk);
    chk("R8", "done held", int'(done_flag), 1);
    done_clr = 1'b1;
    @(negedge clk);
    done_clr = 1'b0;
    chk("R8", "done cleared", int'(done_flag), 0);
    if (noisy) begin
      b0 = bticks;
      wait_tick(b0 + 2, 1'b1, held);
      chk("R2", "no frame from ignored write", int'(held && txd), 1);
      chk("R2", "still idle after ignored write", int'(in_ready), 1);
    end
  endtask

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    int unsigned b0;
    bit held;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_data  = 8'h00;
    done_clr = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "txd in reset", int'(txd), 1);
    chk("R1", "done in reset", int'(done_flag), 0);
    chk("R1", "ready in reset", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "txd after reset", int'(txd), 1);

    // Exhaustive byte sweep, write offset varied against the free-running tick
    for (int d = 0; d < 256; d++) begin
      repeat (d % 23) @(negedge clk);
      send_frame(8'(d), (d % 64) == 7);
    end

    // Slower sample tick: one pulse every third cycle
    samp_div = 3;
    for (int j = 0; j < 16; j++) begin
      repeat (j) @(negedge clk);
      send_frame(8'(j * 17 + 5), j == 9);
    end
    samp_div = 1;

    // Reset in the middle of a frame
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_data  = 8'h00;
    @(negedge clk);
    in_valid = 1'b0;
    b0 = bticks;
    wait_tick(b0 + 3, 1'b1, held);
    chk("R1", "mid-frame line low", int'(txd), 0);
    #1 rst_n = 1'b0;
    #0.5;
    chk("R1", "async reset line", int'(txd), 1);
    chk("R1", "async reset ready", int'(in_ready), 1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (40) @(negedge clk);
    chk("R1", "abandoned frame stays idle", int'(txd), 1);
    chk("R1", "no done after abandon", int'(done_flag), 0);
    send_frame(8'hA5, 1'b0);

    summary();
  end
endmodule